// File: doc/BRIEF.md
# SIMT Secondary Co-Issue Candidate Filter

In each scheduling cycle this block decides which cached secondary instructions may be issued alongside the primary instruction. Each candidate comes from a per-warp instruction-buffer slot. The slot holds the warp ID, split ID, instruction PC, the active mask recorded at fetch time, the functional-unit class and the slot index. The block does not trust the cached mask. For each candidate it presents the warp and split IDs on a combinational lookup port, and the splits table answers with that split's live PC and live active mask.

A candidate is admitted only when all of these hold:
- its split still sits at the cached PC;
- no earlier admission this cycle came from the same warp;
- its unit class matches the unit chosen for co-issue;
- the lanes present in both the cached mask and the live mask leave something to dispatch;
- enough SIMD lane sets remain.

Admitted candidates form a pool that is registered at the evaluation edge. Two saturating counters record capacity denials and unit-class denials.

Top module: `coissue_filter`

## Requirements
- R1: A valid candidate whose live split PC differs from its cached PC is not admitted and increments neither denial counter, even when its unit class also differs.
- R2: The mask of an admitted entry is the bitwise AND of the cached mask and the live split mask. Bit n of a mask is lane n.
- R3: A candidate whose AND-ed mask is all zero is not admitted and increments no counter, even when no lane sets remain.
- R4: An admitted entry reports its active-lane count as the population count of its AND-ed mask. Its sets consumed equal that count divided by SET_WIDTH, rounded up.
- R5: A candidate needing more sets than remain is not admitted, and the capacity-denial counter increases by one for it.
- R6: A candidate whose unit class differs from `cu_fu_i` is not admitted, and the class-denial counter increases by one for it. This check comes after the PC and same-warp checks and before the empty-mask and capacity checks.
- R7: Once a candidate from a warp has been admitted in a cycle, later candidates carrying the same warp ID are skipped and counted nowhere.
- R8: Candidates are examined in ascending index order, starting from `avail_sets_i` remaining sets. Each admission lowers the remainder by its sets before the next candidate is examined. Candidates with `cand_vld_i` low are ignored.
- R9: The pool appears on the outputs one clock after the evaluation edge. At an edge where `eval_i` is low, the pool valid bits clear and the counters hold.
- R10: Each denial counter stops at its all-ones value instead of wrapping.
- R11: After reset the pool is empty and both counters read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| eval_i | input | 1 | Evaluate the candidates at this edge |
| avail_sets_i | input | SETS_W | Lane sets left after the primary issue |
| cu_fu_i | input | FU_W | Unit class chosen for co-issue |
| cand_vld_i | input | NUM_CAND | Candidate present, one bit per candidate |
| cand_warp_i | input | NUM_CAND*WID_W | Warp ID of each candidate |
| cand_split_i | input | NUM_CAND*SID_W | Split ID of each candidate |
| cand_pc_i | input | NUM_CAND*PC_W | Cached instruction PC |
| cand_mask_i | input | NUM_CAND*WARP_SIZE | Mask cached at fetch time |
| cand_fu_i | input | NUM_CAND*FU_W | Unit class of each instruction |
| cand_slot_i | input | NUM_CAND*SLOT_W | Buffer slot index |
| lkp_warp_o | output | NUM_CAND*WID_W | Lookup warp ID towards the splits table |
| lkp_split_o | output | NUM_CAND*SID_W | Lookup split ID towards the splits table |
| lkp_pc_i | input | NUM_CAND*PC_W | Live PC of each looked-up split |
| lkp_mask_i | input | NUM_CAND*WARP_SIZE | Live mask of each looked-up split |
| pool_vld_o | output | NUM_CAND | Candidate admitted in the last evaluation |
| pool_warp_o | output | NUM_CAND*WID_W | Admitted warp ID |
| pool_split_o | output | NUM_CAND*SID_W | Admitted split ID |
| pool_pc_o | output | NUM_CAND*PC_W | Admitted instruction PC |
| pool_mask_o | output | NUM_CAND*WARP_SIZE | Mask to dispatch |
| pool_slot_o | output | NUM_CAND*SLOT_W | Buffer slot index |
| pool_cnt_o | output | NUM_CAND*CNTL_W | Active-lane count |
| pool_sets_o | output | NUM_CAND*SETS_W | Lane sets consumed |
| deny_nosets_o | output | CNT_W | Saturating count of capacity denials |
| deny_fu_o | output | CNT_W | Saturating count of unit-class denials |

## Verification
The capacity budget and the one-per-warp rule act in the same cycle. An early admission lowers the sets left for a later candidate. A skipped same-warp duplicate must consume nothing and count nothing. A long sweep of random cycles makes these cases meet. The stimulus draws warp IDs from a pool of four, so duplicates are frequent, and sets a tight `avail_sets_i` so capacity denials follow admissions. The admitted vector, the per-entry fields and both counters are compared each cycle with an arithmetic scan computed in the bench. Directed cycles also pin down mixed cases: a duplicate that also mismatches its class, and a large candidate denied ahead of a smaller one that still fits.

// File: rtl/coissue_pkg.sv
`timescale 1ns/1ps
// Shared types for the co-issue candidate filter.
// Assumes: verdict codes are internal only and never leave the block.
package coissue_pkg;
    typedef enum logic [2:0] {
        VD_IDLE,
        VD_PC,
        VD_DUP,
        VD_FU,
        VD_EMPTY,
        VD_NOSETS,
        VD_TAKE
    } verdict_e;
endpackage

// File: rtl/lane_popcount.sv
`timescale 1ns/1ps
// Population count of a lane mask.
// Assumes: CW is wide enough to hold W.
module lane_popcount #(
    parameter int W  = 32,
    parameter int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  bits_i,
    output logic [CW-1:0] count_o
);
    // Sum the set bits one at a time.
    always_comb begin
        count_o = '0;
        for (int b = 0; b < W; b++) begin
            count_o = count_o + CW'(bits_i[b]);
        end
    end
endmodule

// File: rtl/cand_qualify.sv
`timescale 1ns/1ps
// Per-candidate qualification: PC agreement, unit-class agreement,
// effective (trimmed) mask, active-lane count and sets needed.
// Assumes: the live PC and mask for this candidate's split arrive in the same cycle.
module cand_qualify #(
    parameter int WARP_SIZE = 32,
    parameter int PC_W      = 32,
    parameter int FU_W      = 2,
    parameter int SET_WIDTH = 8,
    parameter int CNTL_W    = $clog2(WARP_SIZE + 1),
    parameter int SETS_W    = 4
) (
    input  logic [PC_W-1:0]      pc_i,
    input  logic [PC_W-1:0]      live_pc_i,
    input  logic [WARP_SIZE-1:0] mask_i,
    input  logic [WARP_SIZE-1:0] live_mask_i,
    input  logic [FU_W-1:0]      fu_i,
    input  logic [FU_W-1:0]      cu_fu_i,
    output logic                 pc_ok_o,
    output logic                 fu_ok_o,
    output logic [WARP_SIZE-1:0] eff_mask_o,
    output logic [CNTL_W-1:0]    cnt_o,
    output logic [SETS_W-1:0]    sets_o
);
    // Compare the cached PC and unit class with the live ones.
    always_comb begin
        pc_ok_o    = (pc_i == live_pc_i);
        fu_ok_o    = (fu_i == cu_fu_i);
        eff_mask_o = mask_i & live_mask_i;
    end

    lane_popcount #(.W(WARP_SIZE), .CW(CNTL_W)) u_pop (
        .bits_i  (eff_mask_o),
        .count_o (cnt_o)
    );

    // Round the lane count up to whole lane sets.
    always_comb begin
        sets_o = SETS_W'((32'(cnt_o) + SET_WIDTH - 1) / SET_WIDTH);
    end
endmodule

// File: rtl/sat_counter.sv
`timescale 1ns/1ps
// Saturating event counter with a multi-event increment.
// Assumes: INC_W <= CNT_W.
module sat_counter #(
    parameter int CNT_W = 16,
    parameter int INC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [INC_W-1:0] inc_i,
    output logic [CNT_W-1:0] val_o
);
    logic [CNT_W:0] sum;

    // Form the widened sum so that overflow is visible.
    always_comb begin
        sum = {1'b0, val_o} + (CNT_W + 1)'(inc_i);
    end

    // Add, clamping at all ones.
    always_ff @(posedge clk) begin
        if (!rst_n)       val_o <= '0;
        else if (en_i)    val_o <= sum[CNT_W] ? '1 : sum[CNT_W-1:0];
    end

    a_r10_sat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (val_o == '1) |=> (val_o == '1));
    a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (val_o >= $past(val_o)));
endmodule

// File: rtl/coissue_filter.sv
`timescale 1ns/1ps
// Secondary co-issue candidate filter. It scans the candidates in index
// order and admits those that pass the PC, same-warp, unit-class,
// empty-mask and capacity checks. The admitted pool is registered.
// Assumes: the splits-table lookup is combinational and answers in the same cycle.
module coissue_filter
    import coissue_pkg::*;
#(
    parameter int WARP_SIZE = 32,
    parameter int NUM_CAND  = 4,
    parameter int WID_W     = 6,
    parameter int SID_W     = 4,
    parameter int PC_W      = 32,
    parameter int FU_W      = 2,
    parameter int SLOT_W    = 2,
    parameter int SET_WIDTH = 8,
    parameter int MAX_SETS  = 8,
    parameter int CNT_W     = 16,
    localparam int CNTL_W   = $clog2(WARP_SIZE + 1),
    localparam int CEIL_MAX = (WARP_SIZE + SET_WIDTH - 1) / SET_WIDTH,
    localparam int SETS_W   = $clog2(((CEIL_MAX > MAX_SETS) ? CEIL_MAX : MAX_SETS) + 1),
    localparam int INC_W    = $clog2(NUM_CAND + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          eval_i,
    input  logic [SETS_W-1:0]             avail_sets_i,
    input  logic [FU_W-1:0]               cu_fu_i,
    input  logic [NUM_CAND-1:0]           cand_vld_i,
    input  logic [NUM_CAND*WID_W-1:0]     cand_warp_i,
    input  logic [NUM_CAND*SID_W-1:0]     cand_split_i,
    input  logic [NUM_CAND*PC_W-1:0]      cand_pc_i,
    input  logic [NUM_CAND*WARP_SIZE-1:0] cand_mask_i,
    input  logic [NUM_CAND*FU_W-1:0]      cand_fu_i,
    input  logic [NUM_CAND*SLOT_W-1:0]    cand_slot_i,
    output logic [NUM_CAND*WID_W-1:0]     lkp_warp_o,
    output logic [NUM_CAND*SID_W-1:0]     lkp_split_o,
    input  logic [NUM_CAND*PC_W-1:0]      lkp_pc_i,
    input  logic [NUM_CAND*WARP_SIZE-1:0] lkp_mask_i,
    output logic [NUM_CAND-1:0]           pool_vld_o,
    output logic [NUM_CAND*WID_W-1:0]     pool_warp_o,
    output logic [NUM_CAND*SID_W-1:0]     pool_split_o,
    output logic [NUM_CAND*PC_W-1:0]      pool_pc_o,
    output logic [NUM_CAND*WARP_SIZE-1:0] pool_mask_o,
    output logic [NUM_CAND*SLOT_W-1:0]    pool_slot_o,
    output logic [NUM_CAND*CNTL_W-1:0]    pool_cnt_o,
    output logic [NUM_CAND*SETS_W-1:0]    pool_sets_o,
    output logic [CNT_W-1:0]              deny_nosets_o,
    output logic [CNT_W-1:0]              deny_fu_o
);
    logic [WID_W-1:0]     c_warp  [NUM_CAND];
    logic                 pc_ok   [NUM_CAND];
    logic                 fu_ok   [NUM_CAND];
    logic [WARP_SIZE-1:0] eff     [NUM_CAND];
    logic [CNTL_W-1:0]    cnt     [NUM_CAND];
    logic [SETS_W-1:0]    sets    [NUM_CAND];
    verdict_e             verdict [NUM_CAND];
    logic [NUM_CAND-1:0]  take;
    logic [SETS_W-1:0]    rem;
    logic [INC_W-1:0]     inc_nosets, inc_fu;

    logic [NUM_CAND-1:0]  pool_vld_q;
    logic [WARP_SIZE-1:0] pool_mask_q [NUM_CAND];
    logic [CNTL_W-1:0]    pool_cnt_q  [NUM_CAND];
    logic [SETS_W-1:0]    pool_sets_q [NUM_CAND];
    logic [WID_W-1:0]     pool_warp_q [NUM_CAND];
    logic [SID_W-1:0]     pool_split_q[NUM_CAND];
    logic [PC_W-1:0]      pool_pc_q   [NUM_CAND];
    logic [SLOT_W-1:0]    pool_slot_q [NUM_CAND];

    for (genvar g = 0; g < NUM_CAND; g++) begin : g_cand
        assign c_warp[g] = cand_warp_i[g*WID_W +: WID_W];
        assign lkp_warp_o[g*WID_W +: WID_W]   = cand_warp_i[g*WID_W +: WID_W];
        assign lkp_split_o[g*SID_W +: SID_W]  = cand_split_i[g*SID_W +: SID_W];

        cand_qualify #(
            .WARP_SIZE(WARP_SIZE), .PC_W(PC_W), .FU_W(FU_W),
            .SET_WIDTH(SET_WIDTH), .CNTL_W(CNTL_W), .SETS_W(SETS_W)
        ) u_qual (
            .pc_i        (cand_pc_i[g*PC_W +: PC_W]),
            .live_pc_i   (lkp_pc_i[g*PC_W +: PC_W]),
            .mask_i      (cand_mask_i[g*WARP_SIZE +: WARP_SIZE]),
            .live_mask_i (lkp_mask_i[g*WARP_SIZE +: WARP_SIZE]),
            .fu_i        (cand_fu_i[g*FU_W +: FU_W]),
            .cu_fu_i     (cu_fu_i),
            .pc_ok_o     (pc_ok[g]),
            .fu_ok_o     (fu_ok[g]),
            .eff_mask_o  (eff[g]),
            .cnt_o       (cnt[g]),
            .sets_o      (sets[g])
        );

        assign pool_warp_o[g*WID_W +: WID_W]         = pool_warp_q[g];
        assign pool_split_o[g*SID_W +: SID_W]        = pool_split_q[g];
        assign pool_pc_o[g*PC_W +: PC_W]             = pool_pc_q[g];
        assign pool_mask_o[g*WARP_SIZE +: WARP_SIZE] = pool_mask_q[g];
        assign pool_slot_o[g*SLOT_W +: SLOT_W]       = pool_slot_q[g];
        assign pool_cnt_o[g*CNTL_W +: CNTL_W]        = pool_cnt_q[g];
        assign pool_sets_o[g*SETS_W +: SETS_W]       = pool_sets_q[g];
    end
    assign pool_vld_o = pool_vld_q;

    // Ordered scan: assign each candidate a verdict and debit the remaining sets.
    always_comb begin
        logic dup;
        rem  = avail_sets_i;
        take = '0;
        for (int i = 0; i < NUM_CAND; i++) begin
            dup = 1'b0;
            for (int j = 0; j < i; j++) begin
                if (take[j] && (c_warp[j] == c_warp[i])) dup = 1'b1;
            end
            if (!cand_vld_i[i])        verdict[i] = VD_IDLE;
            else if (!pc_ok[i])        verdict[i] = VD_PC;
            else if (dup)              verdict[i] = VD_DUP;
            else if (!fu_ok[i])        verdict[i] = VD_FU;
            else if (cnt[i] == '0)     verdict[i] = VD_EMPTY;
            else if (sets[i] > rem)    verdict[i] = VD_NOSETS;
            else begin
                verdict[i] = VD_TAKE;
                take[i]    = 1'b1;
                rem        = rem - sets[i];
            end
        end
    end

    // Count this cycle's denials of each counted kind.
    always_comb begin
        inc_nosets = '0;
        inc_fu     = '0;
        for (int i = 0; i < NUM_CAND; i++) begin
            if (verdict[i] == VD_NOSETS) inc_nosets = inc_nosets + 1'b1;
            if (verdict[i] == VD_FU)     inc_fu     = inc_fu + 1'b1;
        end
    end

    // Pool valid bits: capture on evaluation, clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      pool_vld_q <= '0;
        else if (eval_i) pool_vld_q <= take;
        else             pool_vld_q <= '0;
    end

    // Pool payload: capture on evaluation, hold otherwise.
    always_ff @(posedge clk) begin
        if (eval_i) begin
            for (int i = 0; i < NUM_CAND; i++) begin
                pool_mask_q[i]  <= eff[i];
                pool_cnt_q[i]   <= cnt[i];
                pool_sets_q[i]  <= sets[i];
                pool_warp_q[i]  <= c_warp[i];
                pool_split_q[i] <= cand_split_i[i*SID_W +: SID_W];
                pool_pc_q[i]    <= cand_pc_i[i*PC_W +: PC_W];
                pool_slot_q[i]  <= cand_slot_i[i*SLOT_W +: SLOT_W];
            end
        end
    end

    sat_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_cnt_nosets (
        .clk(clk), .rst_n(rst_n), .en_i(eval_i), .inc_i(inc_nosets), .val_o(deny_nosets_o)
    );
    sat_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_cnt_fu (
        .clk(clk), .rst_n(rst_n), .en_i(eval_i), .inc_i(inc_fu), .val_o(deny_fu_o)
    );

    // Total sets held by the registered pool, for the capacity check.
    logic [31:0] pool_sets_sum;
    always_comb begin
        pool_sets_sum = '0;
        for (int i = 0; i < NUM_CAND; i++) begin
            if (pool_vld_q[i]) pool_sets_sum = pool_sets_sum + 32'(pool_sets_q[i]);
        end
    end

    a_r8_capacity: assert property (@(posedge clk) disable iff (!rst_n)
        eval_i |=> (pool_sets_sum <= 32'($past(avail_sets_i))));
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_i |=> (pool_vld_q == '0));

    for (genvar a = 0; a < NUM_CAND; a++) begin : g_chk
        a_r3_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
            pool_vld_q[a] |-> (pool_mask_q[a] != '0));
        a_r4_count: assert property (@(posedge clk) disable iff (!rst_n)
            pool_vld_q[a] |-> (32'(pool_cnt_q[a]) == $countones(pool_mask_q[a])));
        a_r4_ceil: assert property (@(posedge clk) disable iff (!rst_n)
            pool_vld_q[a] |-> ((32'(pool_sets_q[a]) * SET_WIDTH >= 32'(pool_cnt_q[a])) &&
                               (32'(pool_sets_q[a]) * SET_WIDTH <  32'(pool_cnt_q[a]) + SET_WIDTH)));
        for (genvar b = a + 1; b < NUM_CAND; b++) begin : g_pair
            a_r7_one_per_warp: assert property (@(posedge clk) disable iff (!rst_n)
                (pool_vld_q[a] && pool_vld_q[b]) |-> (pool_warp_q[a] != pool_warp_q[b]));
        end
    end
endmodule

// File: tb/coissue_filter_bench.sv
`timescale 1ns/1ps
module coissue_filter_bench;
    localparam int WS = 8, NC = 4, WID_W = 3, SID_W = 3, PC_W = 8, FU_W = 2, SLOT_W = 2;
    localparam int SW = 3, MAXS = 8, CNT_W = 4;
    localparam int CNTL_W = $clog2(WS + 1);
    localparam int SETS_W = 4;
    localparam int SAT = (1 << CNT_W) - 1;

    logic clk = 1'b0, rst_n = 1'b0, eval = 1'b0;
    logic [SETS_W-1:0] avail;
    logic [FU_W-1:0] cu_fu;
    logic [NC-1:0] c_vld;
    logic [WID_W-1:0] c_warp [NC];
    logic [SID_W-1:0] c_split[NC];
    logic [PC_W-1:0] c_pc [NC], l_pc [NC];
    logic [WS-1:0] c_mask [NC], l_mask [NC];
    logic [FU_W-1:0] c_fu [NC];
    logic [SLOT_W-1:0] c_slot [NC];

    logic [NC*WID_W-1:0] f_warp, lkp_warp, p_warp;
    logic [NC*SID_W-1:0] f_split, lkp_split, p_split;
    logic [NC*PC_W-1:0] f_pc, f_lpc, p_pc;
    logic [NC*WS-1:0] f_mask, f_lmask, p_mask;
    logic [NC*FU_W-1:0] f_fu;
    logic [NC*SLOT_W-1:0] f_slot, p_slot;
    logic [NC*CNTL_W-1:0] p_cnt;
    logic [NC*SETS_W-1:0] p_sets;
    logic [NC-1:0] p_vld;
    logic [CNT_W-1:0] d_nos, d_fu;

    always_comb begin
        for (int i = 0; i < NC; i++) begin
            f_warp[i*WID_W +: WID_W] = c_warp[i];
            f_split[i*SID_W +: SID_W] = c_split[i];
            f_pc[i*PC_W +: PC_W] = c_pc[i];
            f_lpc[i*PC_W +: PC_W] = l_pc[i];
            f_mask[i*WS +: WS] = c_mask[i];
            f_lmask[i*WS +: WS] = l_mask[i];
            f_fu[i*FU_W +: FU_W] = c_fu[i];
            f_slot[i*SLOT_W +: SLOT_W] = c_slot[i];
        end
    end

    coissue_filter #(.WARP_SIZE(WS), .NUM_CAND(NC), .WID_W(WID_W), .SID_W(SID_W),
        .PC_W(PC_W), .FU_W(FU_W), .SLOT_W(SLOT_W), .SET_WIDTH(SW), .MAX_SETS(MAXS),
        .CNT_W(CNT_W)) u_coissue_filter (
        .clk(clk), .rst_n(rst_n), .eval_i(eval), .avail_sets_i(avail), .cu_fu_i(cu_fu),
        .cand_vld_i(c_vld), .cand_warp_i(f_warp), .cand_split_i(f_split),
        .cand_pc_i(f_pc), .cand_mask_i(f_mask), .cand_fu_i(f_fu), .cand_slot_i(f_slot),
        .lkp_warp_o(lkp_warp), .lkp_split_o(lkp_split), .lkp_pc_i(f_lpc), .lkp_mask_i(f_lmask),
        .pool_vld_o(p_vld), .pool_warp_o(p_warp), .pool_split_o(p_split), .pool_pc_o(p_pc),
        .pool_mask_o(p_mask), .pool_slot_o(p_slot), .pool_cnt_o(p_cnt), .pool_sets_o(p_sets),
        .deny_nosets_o(d_nos), .deny_fu_o(d_fu));

    always #2.5 clk = ~clk;

    int total = 0, bad = 0;
    bit done = 1'b0;
    bit e_vld [NC];
    int e_nos = 0, e_fu = 0;

    task automatic chk(bit ok, string tag, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Expected pool and counters, computed from the requirements.
    task automatic model();
        int rem = int'(avail);
        int nn = 0, nf = 0;
        for (int i = 0; i < NC; i++) begin
            int c, s;
            bit dup = 0;
            e_vld[i] = 0;
            if (!eval || !c_vld[i]) continue;
            if (c_pc[i] != l_pc[i]) continue;
            for (int j = 0; j < i; j++) if (e_vld[j] && c_warp[j] == c_warp[i]) dup = 1;
            if (dup) continue;
            if (c_fu[i] != cu_fu) begin nf++; continue; end
            c = $countones(c_mask[i] & l_mask[i]);
            if (c == 0) continue;
            s = (c + SW - 1) / SW;
            if (s > rem) begin nn++; continue; end
            e_vld[i] = 1;
            rem -= s;
        end
        if (eval) begin
            e_nos = (e_nos + nn > SAT) ? SAT : e_nos + nn;
            e_fu  = (e_fu + nf > SAT) ? SAT : e_fu + nf;
        end
    endtask

    task automatic step(string tag);
        model();
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < NC; i++) begin
            chk(p_vld[i] == e_vld[i], tag, "admit", int'(p_vld[i]), int'(e_vld[i]));
            if (e_vld[i]) begin
                logic [WS-1:0] em;
                int c;
                em = c_mask[i] & l_mask[i];
                c = $countones(em);
                chk(p_mask[i*WS +: WS] == em, tag, "mask", int'(p_mask[i*WS +: WS]), int'(em));
                chk(int'(p_cnt[i*CNTL_W +: CNTL_W]) == c, tag, "count", int'(p_cnt[i*CNTL_W +: CNTL_W]), c);
                chk(int'(p_sets[i*SETS_W +: SETS_W]) == (c + SW - 1) / SW, tag, "sets",
                    int'(p_sets[i*SETS_W +: SETS_W]), (c + SW - 1) / SW);
                chk(p_warp[i*WID_W +: WID_W] == c_warp[i] && p_split[i*SID_W +: SID_W] == c_split[i] &&
                    p_pc[i*PC_W +: PC_W] == c_pc[i] && p_slot[i*SLOT_W +: SLOT_W] == c_slot[i],
                    tag, "fields", int'(p_warp[i*WID_W +: WID_W]), int'(c_warp[i]));
            end
        end
        chk(int'(d_nos) == e_nos, tag, "nosets_count", int'(d_nos), e_nos);
        chk(int'(d_fu) == e_fu, tag, "fu_count", int'(d_fu), e_fu);
    endtask

    // Neutral stimulus: nothing valid, everything else agreeing.
    task automatic base();
        eval = 1; avail = 4'd8; cu_fu = 2'd1; c_vld = '0;
        for (int i = 0; i < NC; i++) begin
            c_warp[i] = WID_W'(i); c_split[i] = SID_W'(i + 1); c_pc[i] = PC_W'(8'h40 + i);
            l_pc[i] = c_pc[i]; c_mask[i] = 8'hFF; l_mask[i] = 8'hFF; c_fu[i] = 2'd1;
            c_slot[i] = SLOT_W'(i);
        end
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        e_nos = 0; e_fu = 0;
        chk(p_vld == '0, "R11", "pool_after_reset", int'(p_vld), 0);
        chk(d_nos == '0 && d_fu == '0, "R11", "counters_after_reset", int'(d_nos) + int'(d_fu), 0);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        base();
        eval = 0;
        do_reset();
        // R2: trimmed mask
        base(); c_vld = 4'b0001; c_mask[0] = 8'b1011_0110; l_mask[0] = 8'b1110_0011;
        step("R2");
        chk(p_mask[7:0] == 8'hA2, "R2", "and_mask", int'(p_mask[7:0]), 8'hA2);
        // R4: ceiling of count over set width 3
        base(); c_vld = 4'b0111; c_mask[0] = 8'h0F; c_mask[1] = 8'h07; c_mask[2] = 8'hFF;
        step("R4");
        chk(p_sets[3:0] == 4'd2 && p_sets[7:4] == 4'd1 && p_sets[11:8] == 4'd3, "R4", "sets_4_3_8",
            int'(p_sets[11:0]), 12'h312);
        // R1: PC mismatch wins over class mismatch
        base(); c_vld = 4'b0001; l_pc[0] = 8'h99; c_fu[0] = 2'd3;
        step("R1");
        // R3: empty trimmed mask, no sets left, not counted
        base(); c_vld = 4'b0001; avail = 0; c_mask[0] = 8'h0F; l_mask[0] = 8'hF0;
        step("R3");
        // R5: three sets needed, one left
        base(); c_vld = 4'b0001; avail = 1;
        step("R5");
        chk(d_nos == 4'd1, "R5", "nosets", int'(d_nos), 1);
        // R6: class mismatch counted
        base(); c_vld = 4'b0010; c_fu[1] = 2'd2;
        step("R6");
        // R7: duplicate warp skipped even with class mismatch
        base(); c_vld = 4'b0111; c_warp[1] = 3'd0; c_warp[2] = 3'd0; c_fu[2] = 2'd0;
        step("R7");
        chk(p_vld == 4'b0001, "R7", "one_per_warp", int'(p_vld), 1);
        // R8: ordered capacity debit
        base(); c_vld = 4'b0111; avail = 3; c_mask[0] = 8'h0F; c_mask[1] = 8'hF0; c_mask[2] = 8'h01;
        step("R8");
        chk(p_vld == 4'b0101, "R8", "ordered_admit", int'(p_vld), 5);
        // R9: no evaluation clears the pool and holds counters
        base(); c_vld = 4'b1111; c_fu[3] = 2'd0; eval = 0;
        step("R9");
        // R10: saturation
        base(); c_vld = 4'b1111;
        for (int i = 0; i < NC; i++) c_fu[i] = 2'd2;
        for (int k = 0; k < 6; k++) step("R10");
        chk(int'(d_fu) == SAT, "R10", "saturated", int'(d_fu), SAT);
        // Sweep: dense same-warp and capacity interactions
        for (int n = 0; n < 3000; n++) begin
            if (n % 40 == 0) begin eval = 0; do_reset(); end
            eval = ($urandom_range(0, 7) != 0);
            avail = SETS_W'($urandom_range(0, 6));
            cu_fu = FU_W'($urandom_range(0, 1));
            for (int i = 0; i < NC; i++) begin
                c_vld[i] = ($urandom_range(0, 7) != 0);
                c_warp[i] = WID_W'($urandom_range(0, 3));
                c_split[i] = SID_W'($urandom_range(0, 7));
                c_pc[i] = PC_W'($urandom_range(0, 255));
                l_pc[i] = ($urandom_range(0, 4) == 0) ? c_pc[i] ^ 8'h04 : c_pc[i];
                c_mask[i] = WS'($urandom_range(0, 255));
                l_mask[i] = ($urandom_range(0, 2) == 0) ? 8'hFF : WS'($urandom_range(0, 255));
                c_fu[i] = ($urandom_range(0, 4) == 0) ? cu_fu + 2'd1 : cu_fu;
                c_slot[i] = SLOT_W'($urandom_range(0, 3));
            end
            step("R8_sweep");
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule